// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block generates the column address for every beat of a memory burst. A controller loads a start column together with a burst length code and a wrap ordering. From the next cycle the block offers one column address per beat on a valid/ready output stream. Each beat carries a flag that marks the final beat of a finite burst. A full-page burst walks the whole row and keeps wrapping until something stops it.

The controller may end a burst on any beat with a terminate input, which covers both a burst-stop and a precharge. It may also load a new start column on any cycle, which abandons the burst in progress and restarts the sequence from the new column. Command timing, refresh and data capture belong to other blocks.

Back-pressure rules for the output stream: a beat transfers on a clock edge where `col_valid` and `col_ready` are both high and `start` is low. While `col_valid` is high and `col_ready` is low, the offered beat is held unchanged. `col_valid` never waits on `col_ready`.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `col_valid` is low, and it stays low until a start is given.
- R2: A cycle with `start` high loads a new burst from any state. From the following cycle `col_valid` is high and `col_addr` equals the loaded `start_col`. A beat offered in the cycle where `start` is high is abandoned, whatever `col_ready` is.
- R3: `bl_code` is sampled only when `start` is high. Its values are 0→1 beat, 1→2, 2→4 and 3→8. Any code with bit 2 set selects full page. Changes to `bl_code` or `wrap_il` during a burst have no effect on that burst.
- R4: With `wrap_il`=0 and a finite length BL, beat k has low log2(BL) bits equal to (start low bits + k) mod BL. The upper bits stay equal to those of the start column.
- R5: With `wrap_il`=1 and a finite length BL, beat k has low log2(BL) bits equal to (start low bits XOR k). The upper bits stay equal to those of the start column.
- R6: In full page, beat k is (start_col + k) mod 2^COL_W. The ordering is sequential whatever `wrap_il` is, and the burst never ends by itself.
- R7: `col_last` is high only on beat BL-1 of a finite burst, and never in full page. With length 1, the single beat is the start column with `col_last` high.
- R8: After the beat with `col_last` high transfers, `col_valid` is low in the next cycle, unless `start` was high.
- R9: While `col_valid` is high and `col_ready` is low, with `start` and `stop` low, `col_addr` and `col_last` hold, and the beat count does not advance.
- R10: `stop` high during a burst, with `start` low, makes `col_valid` low from the next cycle. The beat offered in that cycle transfers only if `col_ready` is high. `stop` while idle has no effect, and `start` wins over `stop` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load a new burst this cycle |
| start_col | input | COL_W | Start column of the new burst |
| bl_code | input | 3 | Burst length code, sampled on start |
| wrap_il | input | 1 | 1 = interleaved order, 0 = sequential, sampled on start |
| stop | input | 1 | Terminate the current burst |
| col_valid | output | 1 | A beat address is offered |
| col_ready | input | 1 | Consumer accepts the offered beat |
| col_addr | output | COL_W | Column address of the offered beat |
| col_last | output | 1 | Offered beat is the final beat of a finite burst |

## Verification
Sequential and interleaved orderings are applied to start columns whose low bits are non-zero, so the two orders give different beat sequences and a wrong modulus or a carry into the upper bits shows up. Each finite length is run at least once. The 8-beat bursts are run under a stalling ready pattern, which shows whether held beats are repeated or skipped. A full-page burst that starts near the top of the row checks the wrap to column zero, the absence of the last flag, and that the interleave request is ignored. Early stop, stop while idle, restart mid-burst, start with stop in the same cycle, and a change of mode inputs mid-burst each separate the priority rules from one another.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Burst configuration captured when a burst is loaded
  typedef struct packed {
    logic [2:0] len_code;   // 0..3 -> 1,2,4,8 beats; bit 2 set -> full page
    logic       interleave; // ordering request
  } burst_cfg_t;

  localparam int unsigned LEN_CODE_W = 3;
endpackage

// File: rtl/bseq_len_decode.sv
module bseq_len_decode #(
  parameter int unsigned COL_W = 10
) (
  input  logic [2:0]       len_code,
  output logic             fullpage,
  output logic [COL_W-1:0] wrap_mask
);
  always_comb begin
    fullpage  = len_code[2];
    wrap_mask = {COL_W{1'b1}};
    if (!fullpage) begin
      wrap_mask = ~({COL_W{1'b1}} << len_code[1:0]);
    end
  end
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  output logic [COL_W-1:0] beat
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat <= '0;
    end else if (load) begin
      beat <= '0;
    end else if (advance) begin
      beat <= beat + 1'b1;
    end
  end
endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen #(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] wrap_mask,
  input  logic             interleave,
  output logic [COL_W-1:0] addr
);
  logic [COL_W-1:0] seq_sum;

  // Carry out of the masked field is dropped bit by bit below
  assign seq_sum = (base & wrap_mask) + beat;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign addr[i] = wrap_mask[i] ? (interleave ? (base[i] ^ beat[i]) : seq_sum[i])
                                  : base[i];
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             wrap_il,
  input  logic             stop,
  output logic             col_valid,
  input  logic             col_ready,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last
);
  logic             valid_q;
  logic [COL_W-1:0] base_q;
  burst_cfg_t       cfg_q;
  logic             lat_fullpage;
  logic [COL_W-1:0] lat_mask;
  logic [COL_W-1:0] beat;
  logic             last_beat;
  logic             xfer;

  bseq_len_decode #(.COL_W(COL_W)) u_dec (
    .len_code  (cfg_q.len_code),
    .fullpage  (lat_fullpage),
    .wrap_mask (lat_mask)
  );

  assign last_beat = valid_q && !lat_fullpage && (beat == lat_mask);
  assign xfer      = valid_q && col_ready && !start;

  bseq_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .advance (xfer && !last_beat),
    .beat    (beat)
  );

  bseq_addr_gen #(.COL_W(COL_W)) u_gen (
    .base       (base_q),
    .beat       (beat),
    .wrap_mask  (lat_mask),
    .interleave (cfg_q.interleave && !lat_fullpage),
    .addr       (col_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      base_q  <= '0;
      cfg_q   <= '0;
    end else if (start) begin
      valid_q        <= 1'b1;
      base_q         <= start_col;
      cfg_q.len_code <= bl_code;
      cfg_q.interleave <= wrap_il;
    end else if (valid_q && stop) begin
      valid_q <= 1'b0;
    end else if (xfer && last_beat) begin
      valid_q <= 1'b0;
    end
  end

  assign col_valid = valid_q;
  assign col_last  = last_beat;
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             stop,
  input logic             col_valid,
  input logic             col_ready,
  input logic [COL_W-1:0] col_addr,
  input logic             col_last,
  input logic             fp,
  input logic [COL_W-1:0] mask
);
  p_load_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col_addr == $past(start_col)));

  p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_ready && !start && !stop && !col_last)
      |=> (((col_addr ^ $past(col_addr)) & ~mask) == '0));

  p_fullpage_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fp && col_valid && col_ready && !start && !stop)
      |=> (col_addr == COL_W'($past(col_addr) + 1'b1)));

  p_end_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_ready && col_last && !start) |=> !col_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready && !start && !stop)
      |=> (col_valid && $stable(col_addr) && $stable(col_last)));

  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !col_valid);
endmodule

bind burst_col_seq bseq_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .start_col (start_col),
  .stop      (stop),
  .col_valid (col_valid),
  .col_ready (col_ready),
  .col_addr  (col_addr),
  .col_last  (col_last),
  .fp        (lat_fullpage),
  .mask      (lat_mask)
);

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
  localparam int unsigned COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       bl_code = '0;
  logic             wrap_il = 1'b0;
  logic             stop = 1'b0;
  logic             col_valid;
  logic             col_ready = 1'b0;
  logic [COL_W-1:0] col_addr;
  logic             col_last;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [COL_W:0] exp_q[$];   // {last, addr}
  string          tag_q[$];

  always #4 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .bl_code(bl_code), .wrap_il(wrap_il), .stop(stop),
    .col_valid(col_valid), .col_ready(col_ready),
    .col_addr(col_addr), .col_last(col_last)
  );

  function automatic logic [COL_W-1:0] exp_addr(logic [COL_W-1:0] b, logic [2:0] code,
                                                 logic il, int k);
    logic [COL_W-1:0] m, low;
    if (code[2]) return COL_W'(b + COL_W'(k));
    m   = COL_W'((1 << code[1:0]) - 1);
    low = il ? ((b & m) ^ COL_W'(k)) : (((b & m) + COL_W'(k)) & m);
    return (b & ~m) | low;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Monitor: compare each transferred beat against the scoreboard
  always @(negedge clk) begin
    if (rst_n && col_valid && col_ready && !start) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected beat actual=%0d expected=none", col_addr);
      end else begin
        logic [COL_W:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({col_last, col_addr} !== e) begin
          fails++;
          $display("FAIL %s actual addr=%0d last=%0d expected addr=%0d last=%0d",
                   t, col_addr, col_last, e[COL_W-1:0], e[COL_W]);
        end
      end
    end
  end

  // Driver: load a burst and queue its expected beats (nfp beats for full page)
  task automatic begin_burst(logic [COL_W-1:0] c, logic [2:0] code, logic il,
                             int nfp, bit with_stop, string tag);
    int n;
    @(posedge clk); #1;
    start = 1'b1; start_col = c; bl_code = code; wrap_il = il; stop = with_stop;
    exp_q.delete(); tag_q.delete();
    n = code[2] ? nfp : (1 << code[1:0]);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back({(!code[2] && k == n - 1), exp_addr(c, code, il, k)});
      tag_q.push_back(tag);
    end
    @(posedge clk); #1;
    start = 1'b0; stop = 1'b0;
  endtask

  task automatic drain(logic [7:0] pat, string tag);
    int i = 0;
    while ((col_valid || exp_q.size() != 0) && i < 400) begin
      col_ready = pat[i % 8];
      @(posedge clk); #1;
      i++;
    end
    col_ready = 1'b0;
    check(exp_q.size() == 0, {tag, " beats left"}, exp_q.size(), 0);
    check(col_valid == 1'b0, {tag, " valid after end"}, col_valid, 0);
  endtask

  // Accept n beats with ready held high, stopping on the n-th when asked
  task automatic stream_n(int n, bit do_stop);
    col_ready = 1'b1;
    for (int k = 0; k < n; k++) begin
      stop = do_stop && (k == n - 1);
      @(posedge clk); #1;
    end
    stop = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(col_valid == 1'b0, "R1 reset valid", col_valid, 0);

    // R7: single beat, flagged last
    begin_burst(10'd37, 3'd0, 1'b0, 0, 0, "R7 len1");
    drain(8'hFF, "R7 R8 len1");

    // R4 sequential orderings
    begin_burst(10'd1, 3'd1, 1'b0, 0, 0, "R4 seq len2");
    drain(8'hFF, "R4 len2");
    begin_burst(10'd9, 3'd2, 1'b0, 0, 0, "R4 seq len4");
    drain(8'hFF, "R4 len4");
    begin_burst(10'd45, 3'd3, 1'b0, 0, 0, "R4 R9 seq len8 stalls");
    drain(8'b1001_0110, "R4 R9 len8");

    // R5 interleaved orderings
    begin_burst(10'd9, 3'd2, 1'b1, 0, 0, "R5 il len4");
    drain(8'hFF, "R5 len4");
    begin_burst(10'd19, 3'd3, 1'b1, 0, 0, "R5 R9 il len8 stalls");
    drain(8'b0110_0011, "R5 R9 len8");

    // R6 full page wraps from the top column, interleave ignored, stopped by R10
    begin_burst(10'd1020, 3'd7, 1'b1, 8, 0, "R6 fullpage wrap");
    stream_n(8, 1);
    check(col_valid == 1'b0, "R10 fullpage stopped", col_valid, 0);
    check(exp_q.size() == 0, "R6 fullpage beats", exp_q.size(), 0);

    // R10 early stop on beat 2 of 8
    begin_burst(10'd100, 3'd3, 1'b0, 0, 0, "R10 early stop");
    exp_q = exp_q[0:2]; tag_q = tag_q[0:2];
    stream_n(3, 1);
    check(col_valid == 1'b0, "R10 early stop valid", col_valid, 0);
    check(exp_q.size() == 0, "R10 early stop beats", exp_q.size(), 0);

    // R10 stop while idle has no effect
    stop = 1'b1;
    repeat (2) @(posedge clk);
    #1 stop = 1'b0;
    check(col_valid == 1'b0, "R10 stop idle", col_valid, 0);

    // R2 restart mid-burst
    begin_burst(10'd200, 3'd3, 1'b0, 0, 0, "R2 first burst");
    stream_n(3, 0);
    begin_burst(10'd515, 3'd2, 1'b1, 0, 0, "R2 restarted burst");
    check(col_addr == 10'd515, "R2 restart first addr", col_addr, 515);
    drain(8'hFF, "R2 restart");

    // R3 mode inputs changed mid-burst are ignored
    begin_burst(10'd14, 3'd2, 1'b1, 0, 0, "R3 latched mode");
    bl_code = 3'd7; wrap_il = 1'b0;
    drain(8'b1101_1011, "R3 latched mode");

    // R10 start wins over stop in the same cycle
    begin_burst(10'd62, 3'd1, 1'b0, 0, 1, "R10 start over stop");
    check(col_valid == 1'b1, "R10 start over stop valid", col_valid, 1);
    drain(8'hFF, "R10 start over stop");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule